// File: doc/BRIEF.md
# Flash Unlock-Sequence Command Decoder

This block sits behind the write port of a parallel NOR flash model or controller. It watches host write cycles and turns the multi-cycle keyed unlock sequences into single-cycle requests. Each write cycle arrives as a one-clock strobe carrying a 19-bit address and an 8-bit data byte. The requests it can issue are: byte program (with target address and data), sector erase (with the sector number), chip erase, identification-mode entry and identification-mode exit. The array, its timing and any analog protection live elsewhere.

The decoder keeps track of how far the host has advanced through a sequence. Any write that does not fit the expected next step sends it back to its idle state. A busy input from the status logic makes it drop writes while an internal operation is in progress. Writes are also dropped while the chip is deselected or the output driver is enabled. The decoder holds an identification-mode flag. While that flag is set, reads at the two lowest addresses are steered to a manufacturer code and a device code, both of which are parameters.

Top module: `jedec_cmd_decoder`

## Requirements
- R1: While reset is held, and in the first cycle after it, every request output is 0, `id_mode` is 0 and `id_rd_vld` is 0. A reset in the middle of a sequence discards the progress made so far.
- R2: Four accepted writes, in order (key address A / AAh, key address B / 55h, key address A / A0h, then any address with any byte), raise `prog_req` for exactly the one cycle after the fourth write. In that cycle `prog_addr` and `prog_data` hold the fourth write's address and data.
- R3: Six accepted writes raise `sect_erase_req` for the one cycle after the sixth write. The six writes are A/AAh, B/55h, A/80h, A/AAh, B/55h, then any address with 30h. In that cycle `sect_addr` equals bits 18..12 of the sixth write's address.
- R4: The same first five writes as R3, followed by A/10h, raise `chip_erase_req` for the one cycle after the sixth write. A sixth write of 10h at any address other than A is a mismatch.
- R5: A/AAh, B/55h, A/90h raises `id_enter` for one cycle after the third write. `id_mode` reads 1 in that same cycle and stays 1 until an exit.
- R6: An accepted write with data F0h raises `id_exit` for one cycle and clears `id_mode` in that same cycle. This holds at any address and at any point in a sequence, so it covers both the single-write form and the keyed three-write form ending A/F0h. The one exception is the data byte of a program (the fourth write of R2), which is programmed instead.
- R7: A write that does not match the expected step returns the decoder to idle. That write is itself discarded, so a new sequence must start again with A/AAh.
- R8: Key addresses A = 5555h and B = 2AAAh are compared on address bits 14..0 only. Bits 18..15 are ignored.
- R9: A write strobe while `busy_in` is 1 is dropped. It issues nothing and leaves the sequence position and `id_mode` unchanged.
- R10: A write strobe while `chip_sel` is 0 or `rd_oe` is 1 is dropped with no effect, and so is a cycle with `wr_stb` at 0. The sequence position is kept.
- R11: When `id_mode` is 1, `rd_addr` = 0 gives `id_rd_vld` = 1 and `id_rd_data` = MFR_CODE, and `rd_addr` = 1 gives the DEV_CODE. Any other address, or `id_mode` at 0, gives `id_rd_vld` = 0 and `id_rd_data` = 0. With ID_RD_REG = 0 the read path is combinational.
- R12: At most one request output is high in any cycle, and each request lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle write strobe |
| chip_sel | input | 1 | Chip selected (1 = selected) |
| rd_oe | input | 1 | Output driver enabled; inhibits writes |
| busy_in | input | 1 | Internal operation in progress |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 19 | Read address for identification steering |
| prog_req | output | 1 | Byte program request pulse |
| prog_addr | output | 19 | Program target address |
| prog_data | output | 8 | Program data byte |
| sect_erase_req | output | 1 | Sector erase request pulse |
| sect_addr | output | 7 | Sector number (address bits 18..12) |
| chip_erase_req | output | 1 | Chip erase request pulse |
| id_enter | output | 1 | Identification-mode entry pulse |
| id_exit | output | 1 | Identification-mode exit pulse |
| id_mode | output | 1 | Identification mode active |
| id_rd_vld | output | 1 | Read address hits an identification byte |
| id_rd_data | output | 8 | Identification byte |

## Verification
The bench builds the decoder with its default parameters. That gives a 19-bit address, key comparison on 15 bits, sectors 4 KB wide (SECT_LSB = 12) and the combinational identification read path. Because the key window is narrower than the address, the bench can drive key writes with bits 18..15 set and show that they still unlock. The 7-bit sector field lets the bench check the sector number against a top-aligned address. The combinational read path lets identification bytes be compared in the same cycle that `rd_addr` changes.

// File: rtl/jcd_pkg.sv
package jcd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_KEY1,
      ST_KEY2,
      ST_PGM,
      ST_ERS1,
      ST_ERS2,
      ST_ERS3
   } seq_state_t;

   localparam logic [7:0] CODE_KEY_A  = 8'hAA;
   localparam logic [7:0] CODE_KEY_B  = 8'h55;
   localparam logic [7:0] CODE_PGM    = 8'hA0;
   localparam logic [7:0] CODE_ERS    = 8'h80;
   localparam logic [7:0] CODE_SECT   = 8'h30;
   localparam logic [7:0] CODE_CHIP   = 8'h10;
   localparam logic [7:0] CODE_ID_IN  = 8'h90;
   localparam logic [7:0] CODE_ID_OUT = 8'hF0;

endpackage

// File: rtl/jcd_wr_qual.sv
module jcd_wr_qual #(
   parameter int ADDR_W = 19,
   parameter int CMP_W  = 15,
   parameter logic [ADDR_W-1:0] KEY_A = 19'h05555,
   parameter logic [ADDR_W-1:0] KEY_B = 19'h02AAA
) (
   input  logic              wr_stb,
   input  logic              chip_sel,
   input  logic              rd_oe,
   input  logic              busy_in,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              wr_ok,
   output logic              at_key_a,
   output logic              at_key_b
);

   localparam logic [ADDR_W-1:0] KEY_MASK = ADDR_W'((64'd1 << CMP_W) - 64'd1);
   localparam logic [ADDR_W-1:0] KEY_A_M  = KEY_A & KEY_MASK;
   localparam logic [ADDR_W-1:0] KEY_B_M  = KEY_B & KEY_MASK;

   logic [ADDR_W-1:0] addr_m;

   assign wr_ok    = wr_stb & chip_sel & ~rd_oe & ~busy_in;
   assign addr_m   = wr_addr & KEY_MASK;
   assign at_key_a = (addr_m == KEY_A_M);
   assign at_key_b = (addr_m == KEY_B_M);

endmodule

// File: rtl/jcd_seq_fsm.sv
module jcd_seq_fsm
   import jcd_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 8,
   parameter int SECT_LSB = 12,
   localparam int SECT_W  = ADDR_W - SECT_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic              at_key_a,
   input  logic              at_key_b,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              sect_req,
   output logic [SECT_W-1:0] sect_addr,
   output logic              chip_req,
   output logic              id_in_req,
   output logic              id_out_req,
   output logic              id_in_set,
   output logic              id_out_set
);

   seq_state_t state_q, state_d;
   logic       prog_d, sect_d, chip_d;

   always_comb begin
      state_d    = state_q;
      prog_d     = 1'b0;
      sect_d     = 1'b0;
      chip_d     = 1'b0;
      id_in_set  = 1'b0;
      id_out_set = 1'b0;
      if (wr_ok) begin
         state_d = ST_IDLE;
         if (state_q == ST_PGM) begin
            prog_d = 1'b1;
         end else if (wr_data == CODE_ID_OUT) begin
            id_out_set = 1'b1;
         end else begin
            case (state_q)
               ST_IDLE: if (at_key_a && wr_data == CODE_KEY_A) state_d = ST_KEY1;
               ST_KEY1: if (at_key_b && wr_data == CODE_KEY_B) state_d = ST_KEY2;
               ST_KEY2: begin
                  if (at_key_a) begin
                     case (wr_data)
                        CODE_PGM:   state_d   = ST_PGM;
                        CODE_ERS:   state_d   = ST_ERS1;
                        CODE_ID_IN: id_in_set = 1'b1;
                        default:    state_d   = ST_IDLE;
                     endcase
                  end
               end
               ST_ERS1: if (at_key_a && wr_data == CODE_KEY_A) state_d = ST_ERS2;
               ST_ERS2: if (at_key_b && wr_data == CODE_KEY_B) state_d = ST_ERS3;
               ST_ERS3: begin
                  if (wr_data == CODE_SECT) begin
                     sect_d = 1'b1;
                  end else if (at_key_a && wr_data == CODE_CHIP) begin
                     chip_d = 1'b1;
                  end
               end
               default: state_d = ST_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         prog_req   <= 1'b0;
         sect_req   <= 1'b0;
         chip_req   <= 1'b0;
         id_in_req  <= 1'b0;
         id_out_req <= 1'b0;
         prog_addr  <= '0;
         prog_data  <= '0;
         sect_addr  <= '0;
      end else begin
         state_q    <= state_d;
         prog_req   <= prog_d;
         sect_req   <= sect_d;
         chip_req   <= chip_d;
         id_in_req  <= id_in_set;
         id_out_req <= id_out_set;
         if (prog_d) begin
            prog_addr <= wr_addr;
            prog_data <= wr_data;
         end
         if (sect_d) begin
            sect_addr <= wr_addr[ADDR_W-1:SECT_LSB];
         end
      end
   end

endmodule

// File: rtl/jcd_id_ctrl.sv
module jcd_id_ctrl #(
   parameter int ADDR_W    = 19,
   parameter int DATA_W    = 8,
   parameter logic [DATA_W-1:0] MFR_CODE = 8'hC5,
   parameter logic [DATA_W-1:0] DEV_CODE = 8'h3A,
   parameter bit ID_RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_in_set,
   input  logic              id_out_set,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              id_mode,
   output logic              id_rd_vld,
   output logic [DATA_W-1:0] id_rd_data
);

   localparam logic [ADDR_W-1:0] MFR_LOC = '0;
   localparam logic [ADDR_W-1:0] DEV_LOC = ADDR_W'(1);

   logic              vld_c;
   logic [DATA_W-1:0] data_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          id_mode <= 1'b0;
      else if (id_out_set) id_mode <= 1'b0;
      else if (id_in_set)  id_mode <= 1'b1;
   end

   always_comb begin
      vld_c  = 1'b0;
      data_c = '0;
      if (id_mode) begin
         if (rd_addr == MFR_LOC) begin
            vld_c  = 1'b1;
            data_c = MFR_CODE;
         end else if (rd_addr == DEV_LOC) begin
            vld_c  = 1'b1;
            data_c = DEV_CODE;
         end
      end
   end

   generate
      if (ID_RD_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               id_rd_vld  <= 1'b0;
               id_rd_data <= '0;
            end else begin
               id_rd_vld  <= vld_c;
               id_rd_data <= data_c;
            end
         end
      end else begin : g_rd_comb
         assign id_rd_vld  = vld_c;
         assign id_rd_data = data_c;
      end
   endgenerate

endmodule

// File: rtl/jedec_cmd_decoder.sv
module jedec_cmd_decoder #(
   parameter int ADDR_W    = 19,
   parameter int DATA_W    = 8,
   parameter int SECT_LSB  = 12,
   parameter int KEY_CMP_W = 15,
   parameter logic [ADDR_W-1:0] KEY_ADDR_A = 19'h05555,
   parameter logic [ADDR_W-1:0] KEY_ADDR_B = 19'h02AAA,
   parameter logic [DATA_W-1:0] MFR_CODE   = 8'hC5,
   parameter logic [DATA_W-1:0] DEV_CODE   = 8'h3A,
   parameter bit ID_RD_REG = 1'b0,
   localparam int SECT_W   = ADDR_W - SECT_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              chip_sel,
   input  logic              rd_oe,
   input  logic              busy_in,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              prog_req,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data,
   output logic              sect_erase_req,
   output logic [SECT_W-1:0] sect_addr,
   output logic              chip_erase_req,
   output logic              id_enter,
   output logic              id_exit,
   output logic              id_mode,
   output logic              id_rd_vld,
   output logic [DATA_W-1:0] id_rd_data
);

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("jedec_cmd_decoder: command codes need DATA_W of 8");
      end
      if (SECT_LSB < 1 || SECT_LSB >= ADDR_W) begin : g_bad_sect
         $error("jedec_cmd_decoder: SECT_LSB must lie inside the address");
      end
      if (KEY_CMP_W < 1 || KEY_CMP_W > ADDR_W) begin : g_bad_cmp
         $error("jedec_cmd_decoder: KEY_CMP_W out of range");
      end
   endgenerate

   logic wr_ok, at_key_a, at_key_b;
   logic id_in_set, id_out_set;

   jcd_wr_qual #(
      .ADDR_W (ADDR_W),
      .CMP_W  (KEY_CMP_W),
      .KEY_A  (KEY_ADDR_A),
      .KEY_B  (KEY_ADDR_B)
   ) u_qual (
      .wr_stb   (wr_stb),
      .chip_sel (chip_sel),
      .rd_oe    (rd_oe),
      .busy_in  (busy_in),
      .wr_addr  (wr_addr),
      .wr_ok    (wr_ok),
      .at_key_a (at_key_a),
      .at_key_b (at_key_b)
   );

   jcd_seq_fsm #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SECT_LSB (SECT_LSB)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_ok      (wr_ok),
      .at_key_a   (at_key_a),
      .at_key_b   (at_key_b),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .prog_req   (prog_req),
      .prog_addr  (prog_addr),
      .prog_data  (prog_data),
      .sect_req   (sect_erase_req),
      .sect_addr  (sect_addr),
      .chip_req   (chip_erase_req),
      .id_in_req  (id_enter),
      .id_out_req (id_exit),
      .id_in_set  (id_in_set),
      .id_out_set (id_out_set)
   );

   jcd_id_ctrl #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .MFR_CODE  (MFR_CODE),
      .DEV_CODE  (DEV_CODE),
      .ID_RD_REG (ID_RD_REG)
   ) u_id (
      .clk        (clk),
      .rst_n      (rst_n),
      .id_in_set  (id_in_set),
      .id_out_set (id_out_set),
      .rd_addr    (rd_addr),
      .id_mode    (id_mode),
      .id_rd_vld  (id_rd_vld),
      .id_rd_data (id_rd_data)
   );

endmodule

// File: rtl/jcd_checker.sv
module jcd_checker (
   input logic clk,
   input logic rst_n,
   input logic wr_stb,
   input logic chip_sel,
   input logic rd_oe,
   input logic busy_in,
   input logic prog_req,
   input logic sect_erase_req,
   input logic chip_erase_req,
   input logic id_enter,
   input logic id_exit,
   input logic id_mode
);

   logic [4:0] req_vec;
   logic       any_req;

   assign req_vec = {prog_req, sect_erase_req, chip_erase_req, id_enter, id_exit};
   assign any_req = |req_vec;

   // R12
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_vec));

   // R12
   single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req && !$past(prog_req)) |=> !prog_req);

   // R9
   busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_in |=> !any_req);

   // R10
   inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_stb || !chip_sel || rd_oe) |=> !any_req);

   // R5
   enter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_enter |-> id_mode);

   // R5
   mode_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_mode) |-> id_enter);

   // R6
   exit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_exit |-> !id_mode);

endmodule

bind jedec_cmd_decoder jcd_checker u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_stb         (wr_stb),
   .chip_sel       (chip_sel),
   .rd_oe          (rd_oe),
   .busy_in        (busy_in),
   .prog_req       (prog_req),
   .sect_erase_req (sect_erase_req),
   .chip_erase_req (chip_erase_req),
   .id_enter       (id_enter),
   .id_exit        (id_exit),
   .id_mode        (id_mode)
);

// File: tb/jedec_cmd_decoder_bench.sv
module jedec_cmd_decoder_bench;

   typedef struct packed {
      logic        stb;
      logic        cs;
      logic        oe;
      logic        busy;
      logic [18:0] addr;
      logic [7:0]  data;
      logic [4:0]  exp;     // {prog, sect, chip, enter, exit}
      logic        exp_idm;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 57;
   localparam vec_t VEC [0:NV-1] = '{
      // R2 program
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd2},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b0,4'd2},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hA0,5'b00000,1'b0,4'd2},
      '{1'b1,1'b1,1'b0,1'b0,19'h12345,8'h5A,5'b10000,1'b0,4'd2},
      // R3 sector erase
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd3},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b0,4'd3},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'h80,5'b00000,1'b0,4'd3},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd3},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b0,4'd3},
      '{1'b1,1'b1,1'b0,1'b0,19'h7B000,8'h30,5'b01000,1'b0,4'd3},
      // R4 chip erase
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b0,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'h80,5'b00000,1'b0,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b0,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'h10,5'b00100,1'b0,4'd4},
      // R5 ID entry
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd5},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b0,4'd5},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'h90,5'b00010,1'b1,4'd5},
      // R6 single-write exit
      '{1'b1,1'b1,1'b0,1'b0,19'h3F00A,8'hF0,5'b00001,1'b0,4'd6},
      // R8 upper address bits ignored on key cycles
      '{1'b1,1'b1,1'b0,1'b0,19'h45555,8'hAA,5'b00000,1'b0,4'd8},
      '{1'b1,1'b1,1'b0,1'b0,19'h7AAAA,8'h55,5'b00000,1'b0,4'd8},
      '{1'b1,1'b1,1'b0,1'b0,19'h55555,8'h90,5'b00010,1'b1,4'd8},
      // R6 keyed exit
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b1,4'd6},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b1,4'd6},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hF0,5'b00001,1'b0,4'd6},
      // R7 wrong data at step 2
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd7},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h54,5'b00000,1'b0,4'd7},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hA0,5'b00000,1'b0,4'd7},
      '{1'b1,1'b1,1'b0,1'b0,19'h00100,8'h77,5'b00000,1'b0,4'd7},
      // R7 wrong address at step 2, offending write not reused
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd7},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd7},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b0,4'd7},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hA0,5'b00000,1'b0,4'd7},
      '{1'b1,1'b1,1'b0,1'b0,19'h00200,8'h11,5'b00000,1'b0,4'd7},
      // R9 busy write dropped, sequence survives
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd9},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b0,4'd9},
      '{1'b1,1'b1,1'b0,1'b1,19'h01234,8'hF0,5'b00000,1'b0,4'd9},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hA0,5'b00000,1'b0,4'd9},
      '{1'b1,1'b1,1'b0,1'b0,19'h00300,8'hC3,5'b10000,1'b0,4'd9},
      // R10 inhibited writes dropped
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd10},
      '{1'b1,1'b0,1'b0,1'b0,19'h01234,8'h00,5'b00000,1'b0,4'd10},
      '{1'b1,1'b1,1'b1,1'b0,19'h01234,8'h00,5'b00000,1'b0,4'd10},
      '{1'b0,1'b1,1'b0,1'b0,19'h01234,8'h00,5'b00000,1'b0,4'd10},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b0,4'd10},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hA0,5'b00000,1'b0,4'd10},
      '{1'b1,1'b1,1'b0,1'b0,19'h00400,8'h3C,5'b10000,1'b0,4'd10},
      // R4 chip-erase code at a non-key address is a mismatch
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b0,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'h80,5'b00000,1'b0,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b0,4'd4},
      '{1'b1,1'b1,1'b0,1'b0,19'h01234,8'h10,5'b00000,1'b0,4'd4},
      // R6 F0h as program data is programmed, not an exit
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hAA,5'b00000,1'b0,4'd6},
      '{1'b1,1'b1,1'b0,1'b0,19'h02AAA,8'h55,5'b00000,1'b0,4'd6},
      '{1'b1,1'b1,1'b0,1'b0,19'h05555,8'hA0,5'b00000,1'b0,4'd6},
      '{1'b1,1'b1,1'b0,1'b0,19'h00500,8'hF0,5'b10000,1'b0,4'd6}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_stb, chip_sel, rd_oe, busy_in;
   logic [18:0] wr_addr, rd_addr;
   logic [7:0]  wr_data;
   logic        prog_req, sect_erase_req, chip_erase_req, id_enter, id_exit, id_mode, id_rd_vld;
   logic [18:0] prog_addr;
   logic [7:0]  prog_data, id_rd_data;
   logic [6:0]  sect_addr;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   jedec_cmd_decoder u_jedec_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .chip_sel(chip_sel), .rd_oe(rd_oe),
      .busy_in(busy_in), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
      .sect_erase_req(sect_erase_req), .sect_addr(sect_addr),
      .chip_erase_req(chip_erase_req), .id_enter(id_enter), .id_exit(id_exit),
      .id_mode(id_mode), .id_rd_vld(id_rd_vld), .id_rd_data(id_rd_data)
   );

   function automatic logic [4:0] pulses();
      return {prog_req, sect_erase_req, chip_erase_req, id_enter, id_exit};
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic stb, input logic cs, input logic oe, input logic bz,
                        input logic [18:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_stb = stb; chip_sel = cs; rd_oe = oe; busy_in = bz; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [18:0] a, input logic [7:0] d);
      drive(1'b1, 1'b1, 1'b0, 1'b0, a, d);
   endtask

   task automatic quiet();
      drive(1'b0, 1'b1, 1'b0, 1'b0, 19'h0, 8'h0);
   endtask

   initial begin
      rst_n = 1'b0; wr_stb = 1'b0; chip_sel = 1'b1; rd_oe = 1'b0; busy_in = 1'b0;
      wr_addr = '0; wr_data = '0; rd_addr = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1", "pulses in reset", 32'(pulses()), 32'h0);
      chk("R1", "id_mode in reset", 32'(id_mode), 32'h0);
      chk("R1", "id_rd_vld in reset", 32'(id_rd_vld), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1", "pulses after reset", 32'(pulses()), 32'h0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].stb, VEC[i].cs, VEC[i].oe, VEC[i].busy, VEC[i].addr, VEC[i].data);
         chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d pulses", i), 32'(pulses()), 32'(VEC[i].exp));
         chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d id_mode", i), 32'(id_mode), 32'(VEC[i].exp_idm));
      end

      // R2 program address and data, then R12 one-cycle width
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0); wr(19'h6ABCD, 8'hE7);
      chk("R2", "prog_req", 32'(prog_req), 32'h1);
      chk("R2", "prog_addr", 32'(prog_addr), 32'h6ABCD);
      chk("R2", "prog_data", 32'(prog_data), 32'hE7);
      quiet();
      chk("R12", "pulses one cycle later", 32'(pulses()), 32'h0);

      // R3 sector number
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h80);
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h2C7FF, 8'h30);
      chk("R3", "sect_erase_req", 32'(sect_erase_req), 32'h1);
      chk("R3", "sect_addr", 32'(sect_addr), 32'h2C);

      // R11 identification reads
      rd_addr = 19'h0; #1;
      chk("R11", "vld outside id mode", 32'(id_rd_vld), 32'h0);
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'h90);
      quiet();
      @(negedge clk); rd_addr = 19'h0; #1;
      chk("R11", "mfr vld", 32'(id_rd_vld), 32'h1);
      chk("R11", "mfr code", 32'(id_rd_data), 32'hC5);
      rd_addr = 19'h1; #1;
      chk("R11", "dev vld", 32'(id_rd_vld), 32'h1);
      chk("R11", "dev code", 32'(id_rd_data), 32'h3A);
      rd_addr = 19'h2; #1;
      chk("R11", "other addr vld", 32'(id_rd_vld), 32'h0);
      chk("R11", "other addr data", 32'(id_rd_data), 32'h0);
      wr(19'h00077, 8'hF0);
      rd_addr = 19'h0; #1;
      chk("R11", "vld after exit", 32'(id_rd_vld), 32'h0);

      // R1 reset mid-sequence discards progress
      wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55); wr(19'h05555, 8'hA0);
      @(negedge clk); rst_n = 1'b0; wr_stb = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      wr(19'h00600, 8'h99);
      chk("R1", "no program after reset", 32'(pulses()), 32'h0);

      @(negedge clk); wr_stb = 1'b0;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule